// File: doc/BRIEF.md
# Bit-Serial Modular Exponentiation Engine

This block raises a message to a power modulo a modulus, `message^exponent mod modulus`. The operands are supplied from outside. No key material is generated or transformed inside. One datapath serves both public-key encryption and decryption, and only the exponent that is presented decides which of the two happens. Every operand is `W` bits wide. `W` defaults to 32 and may be raised as far as 1024.

The engine scans the exponent from its least significant bit, one bit per pass. In each pass a squaring multiplier and a product multiplier run side by side. Both are bit-serial and interleave shifting, adding and reducing. Each of them consumes one multiplier bit per clock, most significant bit first. Each one reduces through a full-width compare-and-subtract that completes within the same clock.

No Montgomery form is used and no partial-sum pipelining is done. The run time is therefore a fixed figure just above `W²` clocks.

To use the block, present the operands and pulse `start_i`. Then wait for the one-cycle `done_o` pulse and read `res_o`.

Top module: `modexp_engine`

## Requirements
- R1: With `mod_i` ≥ 2 and `msg_i` < `mod_i`, the `res_o` seen during the `done_o` pulse equals `msg_i^exp_i mod mod_i` for the operands captured at the accepted start. This includes exponent 1, which returns the message.
- R2: An exponent of zero yields 1 whenever `mod_i` ≥ 2.
- R3: A modulus of 1, with a message of 0, yields 0. While such a run is in progress the result register holds 0.
- R4: After reset, `done_o` and `res_o` are 0. `done_o` is high for exactly one cycle per completed run.
- R5: `done_o` rises exactly `W*(W+2)` clock edges after the edge that samples an accepted `start_i`. This is 1088 edges at `W` = 32.
- R6: From the `done_o` pulse until the next accepted start, `res_o` holds its value, whatever the operand inputs do.
- R7: A `start_i` pulse that arrives while a run is in progress is ignored. The captured modulus stays unchanged, and the run finishes on its original schedule with its original operands.
- R8: The same engine both encrypts and decrypts. With modulus 3233, public exponent 17 and private exponent 2753, encrypting any message below 3233 and then decrypting the result returns that message.
- R9: The all-ones exponent and the all-ones modulus (every adder and subtracter bit carrying) give correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run; sampled only when idle |
| msg_i | input | W | Message, less than the modulus |
| exp_i | input | W | Exponent |
| mod_i | input | W | Modulus, nonzero |
| res_o | output | W | Result of the last run |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The squaring multiplier and the product multiplier always finish in the same cycle. When the current exponent bit is 1, that same edge writes the new base and the new partial result. The product must therefore use the base from before that edge, not the freshly squared one.

Exponents that are dense in ones make this write-back collision happen on every pass. The all-ones exponent and the full-width modulus are such cases, and random operands add many more.

Every result is compared with a square-and-multiply model in the bench, so a product taken from the wrong base value shows up as a wrong result. The exact completion edge is checked as well, and so is the hold of the result after completion.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

    // Sequencer state for the exponent scan
    typedef enum logic [1:0] {
        XS_IDLE   = 2'd0,
        XS_LAUNCH = 2'd1,
        XS_WAIT   = 2'd2
    } xp_state_e;

    // Role of each multiplier lane in the generate loop
    localparam int LANE_SQUARE  = 0;
    localparam int LANE_PRODUCT = 1;
    localparam int NUM_LANES    = 2;

endpackage

// File: rtl/modexp_redstep.sv
// One interleaved step: acc' = (2*acc + bit*a) mod m, with acc, a < m.
module modexp_redstep #(
    parameter int W = 32
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] m_i,
    input  logic         bit_i,
    output logic [W-1:0] acc_o
);
    logic [W:0] mx, dbl, red1, sum, red2;

    always_comb begin
        mx   = {1'b0, m_i};
        dbl  = {acc_i, 1'b0};
        red1 = (dbl >= mx) ? dbl - mx : dbl;
        sum  = red1 + {1'b0, a_i};
        red2 = (sum >= mx) ? sum - mx : sum;
        acc_o = W'(bit_i ? red2 : red1);
    end
endmodule

// File: rtl/modexp_mulser.sv
// Bit-serial modular multiplier: p = a*b mod m, b scanned MSB first.
module modexp_mulser #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] m_i,
    output logic [W-1:0] p_o,
    output logic         done_o
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(W);
    localparam logic [CW-1:0] CNT_LAST = CW'(1);

    logic [W-1:0]  acc_q, a_q, b_q, m_q, acc_nxt;
    logic [CW-1:0] cnt_q;
    logic          busy_q, done_q;

    modexp_redstep #(.W(W)) u_step (
        .acc_i (acc_q),
        .a_i   (a_q),
        .m_i   (m_q),
        .bit_i (b_q[W-1]),
        .acc_o (acc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            a_q    <= '0;
            b_q    <= '0;
            m_q    <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go_i) begin
                acc_q  <= '0;
                a_q    <= a_i;
                b_q    <= b_i;
                m_q    <= m_i;
                cnt_q  <= CNT_FULL;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                acc_q <= acc_nxt;
                b_q   <= {b_q[W-2:0], 1'b0};
                cnt_q <= cnt_q - CNT_LAST;
                if (cnt_q == CNT_LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign p_o    = acc_q;
    assign done_o = done_q;

    // R1: partial product stays fully reduced throughout a run
    p_acc_reduced_r1: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (acc_q < m_q));

    // R5: completion only ends a run that was in progress
    p_done_ends_run_r5: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(busy_q));

    // R5: a launch always starts a run on the next cycle
    p_go_starts_r5: assert property (@(posedge clk) disable iff (rst)
        go_i |=> busy_q);
endmodule

// File: rtl/modexp_engine.sv
module modexp_engine
    import modexp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] msg_i,
    input  logic [W-1:0] exp_i,
    input  logic [W-1:0] mod_i,
    output logic [W-1:0] res_o,
    output logic         done_o
);
    localparam int IW = (W > 2) ? $clog2(W) : 1;
    localparam logic [IW-1:0] IDX_LAST = IW'(W - 1);
    localparam logic [IW-1:0] IDX_ONE  = IW'(1);
    localparam logic [W-1:0]  ONE_W    = W'(1);

    xp_state_e     state_q;
    logic [W-1:0]  mod_q, exp_q, base_q, res_q;
    logic [IW-1:0] idx_q;
    logic          done_q;
    logic          go;

    logic [W-1:0]  lane_p    [NUM_LANES];
    logic          lane_done [NUM_LANES];

    assign go = (state_q == XS_LAUNCH);

    // Lane 0 squares the base, lane 1 multiplies the partial result by it
    for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
        modexp_mulser #(.W(W)) u_mul (
            .clk    (clk),
            .rst    (rst),
            .go_i   (go),
            .a_i    (base_q),
            .b_i    ((gi == LANE_SQUARE) ? base_q : res_q),
            .m_i    (mod_q),
            .p_o    (lane_p[gi]),
            .done_o (lane_done[gi])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XS_IDLE;
            mod_q   <= '0;
            exp_q   <= '0;
            base_q  <= '0;
            res_q   <= '0;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                XS_IDLE: begin
                    if (start_i) begin
                        mod_q   <= mod_i;
                        exp_q   <= exp_i;
                        base_q  <= msg_i;
                        res_q   <= (mod_i == ONE_W) ? '0 : ONE_W;
                        idx_q   <= '0;
                        state_q <= XS_LAUNCH;
                    end
                end
                XS_LAUNCH: state_q <= XS_WAIT;
                XS_WAIT: begin
                    if (lane_done[LANE_SQUARE]) begin
                        base_q <= lane_p[LANE_SQUARE];
                        if (exp_q[0]) res_q <= lane_p[LANE_PRODUCT];
                        exp_q <= {1'b0, exp_q[W-1:1]};
                        if (idx_q == IDX_LAST) begin
                            done_q  <= 1'b1;
                            state_q <= XS_IDLE;
                        end else begin
                            idx_q   <= idx_q + IDX_ONE;
                            state_q <= XS_LAUNCH;
                        end
                    end
                end
                default: state_q <= XS_IDLE;
            endcase
        end
    end

    assign res_o  = res_q;
    assign done_o = done_q;

    // R4: completion is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R7: captured modulus cannot change while a run is active
    p_busy_holds_mod_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q != XS_IDLE) |=> $stable(mod_q));

    // R6: result is held while idle and no start arrives
    p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == XS_IDLE && !start_i) |=> $stable(res_q));

    // R3: a unit modulus keeps the result at zero during the run
    p_unit_mod_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q != XS_IDLE && mod_q == ONE_W) |-> (res_q == '0));

    // R5: both lanes finish in the same cycle
    p_lanes_lockstep_r5: assert property (@(posedge clk) disable iff (rst)
        lane_done[LANE_SQUARE] |-> lane_done[LANE_PRODUCT]);
endmodule

// File: tb/sim_modexp_engine.sv
module sim_modexp_engine;
    localparam int W = 32;
    localparam int unsigned LAT = W * (W + 2);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [W-1:0] msg_i = '0, exp_i = '0, mod_i = '0;
    logic [W-1:0] res_o;
    logic         done_o;

    int unsigned n_run = 0, n_fail = 0, n_cyc = 0;
    bit          ended = 1'b0;

    always #5 clk = ~clk;

    modexp_engine #(.W(W)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i),
        .msg_i(msg_i), .exp_i(exp_i), .mod_i(mod_i),
        .res_o(res_o), .done_o(done_o)
    );

    function automatic logic [W-1:0] ref_pow(logic [W-1:0] b, logic [W-1:0] e, logic [W-1:0] m);
        longint unsigned r, bb, mm;
        mm = {32'd0, m};
        r  = 64'd1 % mm;
        bb = {32'd0, b} % mm;
        for (int i = 0; i < W; i++) begin
            if (e[i]) r = (r * bb) % mm;
            bb = (bb * bb) % mm;
        end
        return r[W-1:0];
    endfunction

    task automatic check(bit ok, string req, longint unsigned act, longint unsigned exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [W-1:0] m, input logic [W-1:0] e, input logic [W-1:0] md,
                          input bit disturb, output logic [W-1:0] res, output int unsigned lat);
        int unsigned cyc;
        @(negedge clk);
        msg_i = m; exp_i = e; mod_i = md; start_i = 1'b1;
        cyc = 0;
        do begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start_i = 1'b0;
            if (disturb && cyc == 100) begin
                start_i = 1'b1;
                msg_i = 32'd3; exp_i = 32'd5; mod_i = 32'd7;
            end
        end while (!done_o && cyc < 5000);
        res = res_o;
        lat = cyc - 1;
    endtask

    task automatic do_case(input logic [W-1:0] m, input logic [W-1:0] e, input logic [W-1:0] md,
                           input string req);
        logic [W-1:0] r;
        int unsigned lat;
        run_op(m, e, md, 1'b0, r, lat);
        check(r == ref_pow(m, e, md), req, r, ref_pow(m, e, md));
        check(lat == LAT, "R5 latency", lat, LAT);
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 150000 && !ended) begin
            ended = 1'b1;
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=%0d expected=%0d", n_cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] r, r0, c, md, m, e;
        int unsigned lat;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4: reset state
        check(done_o == 1'b0, "R4 reset done", done_o, 0);
        check(res_o == '0, "R4 reset result", res_o, 0);

        // R1: exponent 1 returns the message
        do_case(32'd123456, 32'd1, 32'd1000003, "R1 exp one");
        // R2: exponent zero
        run_op(32'd777, 32'd0, 32'd1000003, 1'b0, r, lat);
        check(r == 32'd1, "R2 exp zero", r, 1);
        // R3: unit modulus
        run_op(32'd0, 32'hDEAD_BEEF, 32'd1, 1'b0, r, lat);
        check(r == '0, "R3 unit modulus", r, 0);
        // R9: all-ones exponent and all-ones modulus
        do_case(32'h1234_5677, 32'hFFFF_FFFF, 32'hFFFF_FFFB, "R9 all-ones exponent");
        do_case(32'hFFFF_FFFE, 32'h8765_4321, 32'hFFFF_FFFF, "R9 all-ones modulus");
        do_case(32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 both all-ones");

        // R4 and R6: pulse width and hold after completion
        run_op(32'd99, 32'd65537, 32'd1000003, 1'b0, r, lat);
        r0 = r;
        @(negedge clk);
        check(done_o == 1'b0, "R4 done single cycle", done_o, 0);
        for (int k = 0; k < 20; k++) begin
            msg_i = $urandom; exp_i = $urandom; mod_i = $urandom;
            @(negedge clk);
        end
        check(res_o == r0, "R6 result held", res_o, r0);

        // R7: start while busy is ignored
        run_op(32'd4242, 32'hA5A5_0F0F, 32'd99991, 1'b1, r, lat);
        check(r == ref_pow(32'd4242, 32'hA5A5_0F0F, 32'd99991), "R7 start ignored result",
              r, ref_pow(32'd4242, 32'hA5A5_0F0F, 32'd99991));
        check(lat == LAT, "R7 start ignored latency", lat, LAT);

        // R8: encrypt then decrypt with one engine
        for (int k = 0; k < 3; k++) begin
            m = 32'($urandom % 3233);
            run_op(m, 32'd17, 32'd3233, 1'b0, c, lat);
            check(c == ref_pow(m, 32'd17, 32'd3233), "R8 encrypt", c, ref_pow(m, 32'd17, 32'd3233));
            run_op(c, 32'd2753, 32'd3233, 1'b0, r, lat);
            check(r == m, "R8 decrypt round trip", r, m);
        end

        // R1: constrained random operands
        for (int k = 0; k < 40; k++) begin
            md = $urandom;
            if (k % 3 == 0) md = md | 32'h8000_0000;
            if (md < 32'd2) md = 32'd2;
            m = $urandom % md;
            e = $urandom;
            if (k % 5 == 0) e = e | 32'hFFFF_0000;
            do_case(m, e, md, "R1 random");
        end

        ended = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule